// File: doc/BRIEF.md
# Pin-Driven Program Memory Sequencer

This block is the control logic behind an on-chip program memory that an external programmer drives through a handful of pins while the rest of the device is held idle. The programmer steps a 13-bit address register and a 4-bit operation-code register with edge-sensitive pins and clears them with level-sensitive pins. It then commits the chosen operation with a separate active-low strobe. Committing runs one of six operations: unlock, byte write, lock, identification-code write, lock-status read and identification-code read, plus a plain memory read. A bidirectional byte port returns results, and its direction follows the code-clear pin.

Protection rests on a lock status flag and a one-time lock cell. Clearing the address drops the lock status. Only an unlock can raise it again, and only while the lock cell has never been written. All pins are asynchronous. They pass through two-flop synchronizers. The strobe's low time is measured in system clock cycles, and a strobe that is too short is refused and flagged. The memory array and the 64-byte identification store are behavioural arrays that power up blank (all ones).

Top module: `prog_seq`

## Requirements
- R1: The 4-bit code register is cleared while `code_clr` is high, and every rising edge of `code_step` adds one (modulo 16).
- R2: On a committed strobe the code selects the operation: 1 memory read, 2 unlock, 3 memory write, 4 lock, 5 ID write, 9 lock-status read (result is 0x00 or 0x01 in bit 0), 10 ID read; any other code does nothing.
- R3: While `addr_clr_n` is low the address register is 0 and the lock status is 0.
- R4: Every rising edge of `addr_step` adds one to the 13-bit address shown on `mem_addr`.
- R5: The strobe `commit_n` runs its operation when it returns high after being low for at least `CYC_100NS` clock cycles, or at least `100*CYC_100NS` for codes 3 and 5. A shorter strobe runs nothing and sets `pulse_err`, and a strobe of sufficient width clears it.
- R6: Unlock sets the lock status to 1 only while the lock cell still holds 1.
- R7: Lock, allowed only while the status is 1, clears the lock cell and the status, and after it the status never returns to 1.
- R8: While the status is 0, codes 1, 3, 4 and 5 have no effect; codes 9 and 10 still return their results.
- R9: A memory write stores the AND of the old byte and `port_in`, so it can only turn ones into zeros; unwritten bytes read 0xFF.
- R10: The ID store holds 64 bytes at addresses 0 to 63. An ID read at a higher address returns 0xFF, and an ID write there has no effect.
- R11: `port_oe` is high while the synchronized `code_clr` is high. `port_out` holds the result of the most recent read-type operation that was allowed to run.
- R12: `standby` is high while the synchronized strobe is high, or while it is low with a code register of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_clr_n | input | 1 | Active-low level: clears address and lock status |
| addr_step | input | 1 | Rising edge increments the address |
| code_clr | input | 1 | Active-high level: clears the code register, turns port to output |
| code_step | input | 1 | Rising edge increments the code register |
| commit_n | input | 1 | Active-low strobe committing the selected operation |
| port_in | input | 8 | Data from the byte port (write data) |
| port_out | output | 8 | Result byte driven onto the port |
| port_oe | output | 1 | Port output enable |
| mem_addr | output | 13 | Current address register |
| lock_status | output | 1 | Lock status flag (1 = operations enabled) |
| pulse_err | output | 1 | Last strobe was too short |
| standby | output | 1 | Memory is in standby |

## Verification
Each pin change passes through two synchronizer flops, so a register it updates changes on the third rising clock edge after the change. The bench holds every pin level for at least three cycles and samples five cycles later. A committed operation lands on the third edge after the strobe returns high. Results are then read through the port by raising the code-clear pin and sampling four cycles later. Strobe widths are given in whole clock cycles. The synchronizer delays both strobe edges equally, so the measured width is exactly the number of cycles the pin was held low, which lets the bench test one cycle below each threshold and exactly on it.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_READ   = 4'd1,
        OP_UNLOCK = 4'd2,
        OP_WRITE  = 4'd3,
        OP_LOCK   = 4'd4,
        OP_IDWR   = 4'd5,
        OP_LSTAT  = 4'd9,
        OP_IDRD   = 4'd10
    } op_e;

    typedef struct packed {
        logic       fire;
        logic [3:0] code;
    } op_req_t;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    function automatic logic is_long_op(input logic [3:0] code);
        return (code == OP_WRITE) || (code == OP_IDWR);
    endfunction

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter int  W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta;
    logic [W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta  <= RST_VAL;
            lvl   <= RST_VAL;
            lvl_q <= RST_VAL;
        end else begin
            meta  <= pin;
            lvl   <= meta;
            lvl_q <= lvl;
        end
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/ps_regs.sv
module ps_regs #(
    parameter int ADDR_W = 13,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_clr_act,
    input  logic              addr_inc,
    input  logic              code_clr_act,
    input  logic              code_inc,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            code_q <= '0;
        end else begin
            if (addr_clr_act)
                addr_q <= '0;
            else if (addr_inc)
                addr_q <= addr_q + 1'b1;

            if (code_clr_act)
                code_q <= '0;
            else if (code_inc)
                code_q <= code_q + 1'b1;
        end
    end
endmodule

// File: rtl/ps_strobe.sv
module ps_strobe
    import prog_seq_pkg::*;
#(
    parameter int CYC_100NS = 2,
    parameter int LONG_MULT = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_lvl,
    input  logic       strobe_rise,
    input  logic [3:0] code,
    output op_req_t    req,
    output logic       err
);
    localparam int LONG_CYC = CYC_100NS * LONG_MULT;
    localparam int CNT_W    = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(CYC_100NS);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);

    logic [CNT_W-1:0] low_cnt;
    logic             wide_ok;

    assign wide_ok  = low_cnt >= (is_long_op(code) ? LONG_LIM : SHORT_LIM);
    assign req.fire = strobe_rise & wide_ok;
    assign req.code = code;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            err     <= 1'b0;
        end else if (!strobe_lvl) begin
            if (low_cnt != LONG_LIM)
                low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
            if (strobe_rise)
                err <= !wide_ok;
        end
    end
endmodule

// File: rtl/ps_engine.sv
module ps_engine
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int MEM_AW   = 10,
    parameter int ID_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  op_req_t           req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              addr_clr_act,
    output logic              lock_status,
    output logic              lock_cell,
    output logic [DATA_W-1:0] result
);
    localparam int MEM_DEPTH = 1 << MEM_AW;
    localparam int ID_AW     = $clog2(ID_DEPTH);

    logic [DATA_W-1:0] mem    [MEM_DEPTH];
    logic [DATA_W-1:0] id_mem [ID_DEPTH];

    logic [MEM_AW-1:0] mem_idx;
    logic [ID_AW-1:0]  id_idx;
    logic              id_hit;

    assign mem_idx = addr[MEM_AW-1:0];
    assign id_idx  = addr[ID_AW-1:0];
    assign id_hit  = addr < ADDR_W'(ID_DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_status <= 1'b0;
            lock_cell   <= 1'b1;
            result      <= DATA_W'(BLANK_BYTE);
            for (int i = 0; i < MEM_DEPTH; i++) mem[i]    <= DATA_W'(BLANK_BYTE);
            for (int i = 0; i < ID_DEPTH;  i++) id_mem[i] <= DATA_W'(BLANK_BYTE);
        end else begin
            if (req.fire) begin
                case (op_e'(req.code))
                    OP_READ:   if (lock_status) result <= mem[mem_idx];
                    OP_UNLOCK: if (lock_cell) lock_status <= 1'b1;
                    OP_WRITE:  if (lock_status) mem[mem_idx] <= mem[mem_idx] & wdata;
                    OP_LOCK: begin
                        if (lock_status) begin
                            lock_cell   <= 1'b0;
                            lock_status <= 1'b0;
                        end
                    end
                    OP_IDWR:   if (lock_status && id_hit) id_mem[id_idx] <= id_mem[id_idx] & wdata;
                    OP_LSTAT:  result <= DATA_W'(lock_status);
                    OP_IDRD:   result <= id_hit ? id_mem[id_idx] : DATA_W'(BLANK_BYTE);
                    default: ;
                endcase
            end
            if (addr_clr_act)
                lock_status <= 1'b0;
        end
    end
endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CODE_W    = 4,
    parameter int MEM_AW    = 10,
    parameter int ID_DEPTH  = 64,
    parameter int CYC_100NS = 2,
    parameter int LONG_MULT = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_clr_n,
    input  logic              addr_step,
    input  logic              code_clr,
    input  logic              code_step,
    input  logic              commit_n,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              lock_status,
    output logic              pulse_err,
    output logic              standby
);
    localparam int NPIN = 5;
    localparam logic [NPIN-1:0] PIN_IDLE = 5'b10001;

    logic [NPIN-1:0] pins, pin_lvl, pin_rise;
    logic            addr_clr_act, code_clr_act, strobe_lvl;
    logic [CODE_W-1:0] code_q;
    logic            lock_cell;
    op_req_t         req;

    assign pins = {commit_n, code_step, code_clr, addr_step, addr_clr_n};

    ps_sync #(.W(NPIN), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst(rst), .pin(pins), .lvl(pin_lvl), .rise(pin_rise)
    );

    assign addr_clr_act = !pin_lvl[0];
    assign code_clr_act = pin_lvl[2];
    assign strobe_lvl   = pin_lvl[4];

    ps_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst(rst),
        .addr_clr_act(addr_clr_act), .addr_inc(pin_rise[1]),
        .code_clr_act(code_clr_act), .code_inc(pin_rise[3]),
        .addr_q(mem_addr), .code_q(code_q)
    );

    ps_strobe #(.CYC_100NS(CYC_100NS), .LONG_MULT(LONG_MULT)) u_strobe (
        .clk(clk), .rst(rst),
        .strobe_lvl(strobe_lvl), .strobe_rise(pin_rise[4]),
        .code(4'(code_q)), .req(req), .err(pulse_err)
    );

    ps_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW), .ID_DEPTH(ID_DEPTH)) u_engine (
        .clk(clk), .rst(rst), .req(req), .addr(mem_addr), .wdata(port_in),
        .addr_clr_act(addr_clr_act), .lock_status(lock_status),
        .lock_cell(lock_cell), .result(port_out)
    );

    assign port_oe = code_clr_act;
    assign standby = strobe_lvl || (code_q == '0);
endmodule

// File: rtl/prog_seq_sva.sv
module prog_seq_sva #(
    parameter int ADDR_W = 13,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_clr_act,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CODE_W-1:0] code_q,
    input logic              lock_status,
    input logic              lock_cell
);
    AST_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
        (code_q != $past(code_q)) |-> (code_q == CODE_W'($past(code_q) + 1'b1) || code_q == '0)); // R1

    AST_ADDR_CLR_LOCK: assert property (@(posedge clk) disable iff (rst)
        addr_clr_act |=> (!lock_status && mem_addr == '0)); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_addr != $past(mem_addr)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1) || mem_addr == '0)); // R4

    AST_UNLOCK_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_status) |-> lock_cell); // R6

    AST_CELL_STAYS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !lock_cell |=> !lock_cell); // R7

    AST_NO_RELOCK: assert property (@(posedge clk) disable iff (rst)
        !lock_cell |-> !lock_status); // R7
endmodule

bind prog_seq prog_seq_sva #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_sva (
    .clk(clk), .rst(rst), .addr_clr_act(addr_clr_act), .mem_addr(mem_addr),
    .code_q(code_q), .lock_status(lock_status), .lock_cell(lock_cell)
);

// File: tb/prog_seq_bench.sv
module prog_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SHORT_OK   = 3;
    localparam int LONG_OK    = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_clr_n = 1'b1, addr_step = 1'b0, code_clr = 1'b0;
    logic        code_step = 1'b0, commit_n = 1'b1;
    logic [7:0]  port_in = 8'h00;
    logic [7:0]  port_out;
    logic        port_oe, lock_status, pulse_err, standby;
    logic [12:0] mem_addr;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_seq u_prog_seq (
        .clk(clk), .rst(rst), .addr_clr_n(addr_clr_n), .addr_step(addr_step),
        .code_clr(code_clr), .code_step(code_step), .commit_n(commit_n),
        .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
        .mem_addr(mem_addr), .lock_status(lock_status),
        .pulse_err(pulse_err), .standby(standby)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_code(input int n);
        for (int i = 0; i < n; i++) begin
            code_step = 1'b1; tick(3); code_step = 1'b0; tick(3);
        end
    endtask

    task automatic pulse_addr(input int n);
        for (int i = 0; i < n; i++) begin
            addr_step = 1'b1; tick(3); addr_step = 1'b0; tick(3);
        end
    endtask

    task automatic run_op(input int code, input int width);
        code_clr = 1'b1; tick(3); code_clr = 1'b0; tick(3);
        pulse_code(code);
        commit_n = 1'b0; tick(width); commit_n = 1'b1; tick(5);
    endtask

    task automatic read_port(input string req, input int exp);
        code_clr = 1'b1; tick(4);
        check("R11 port_oe", int'(port_oe), 1);
        check(req, int'(port_out), exp);
        code_clr = 1'b0; tick(4);
    endtask

    task automatic go_addr(input int a);
        addr_clr_n = 1'b0; tick(4); addr_clr_n = 1'b1; tick(4);
        pulse_addr(a);
    endtask

    task automatic t_reset();
        check("R3 reset addr", int'(mem_addr), 0);
        check("R3 reset lock", int'(lock_status), 0);
        check("R5 reset err", int'(pulse_err), 0);
        check("R11 reset oe", int'(port_oe), 0);
        check("R12 reset standby", int'(standby), 1);
    endtask

    task automatic t_denied_write();
        run_op(9, SHORT_OK);
        read_port("R2 status while locked", 8'h00);
        go_addr(5);
        check("R4 addr after 5 steps", int'(mem_addr), 5);
        port_in = 8'h00;
        run_op(3, LONG_OK + 10);
        run_op(2, SHORT_OK);
        check("R6 unlock", int'(lock_status), 1);
        run_op(1, SHORT_OK);
        read_port("R8 locked write ignored, R9 blank", 8'hFF);
    endtask

    task automatic t_write_and();
        port_in = 8'h3C; run_op(3, LONG_OK + 10);
        run_op(1, SHORT_OK);
        read_port("R9 first write", 8'h3C);
        port_in = 8'hF0; run_op(3, LONG_OK + 10);
        run_op(1, SHORT_OK);
        read_port("R9 write ANDs", 8'h30);
    endtask

    task automatic t_width();
        port_in = 8'h00;
        run_op(3, LONG_OK - 1);
        check("R5 short write flagged", int'(pulse_err), 1);
        run_op(1, SHORT_OK);
        check("R5 valid strobe clears err", int'(pulse_err), 0);
        read_port("R5 short write no effect", 8'h30);
        run_op(9, 1);
        check("R5 short read flagged", int'(pulse_err), 1);
        read_port("R5 short read no effect", 8'h30);
        run_op(3, LONG_OK);
        check("R5 exact long width", int'(pulse_err), 0);
        run_op(1, 2);
        check("R5 exact short width", int'(pulse_err), 0);
        read_port("R5 write at threshold", 8'h00);
    endtask

    task automatic t_code_clear();
        code_clr = 1'b1; tick(3); code_clr = 1'b0; tick(3);
        pulse_code(4);
        code_clr = 1'b1; tick(3); code_clr = 1'b0; tick(3);
        check("R11 oe low", int'(port_oe), 0);
        pulse_code(9);
        commit_n = 1'b0; tick(SHORT_OK); commit_n = 1'b1; tick(5);
        read_port("R1 code cleared then counted", 8'h01);
    endtask

    task automatic t_standby();
        code_clr = 1'b1; tick(3); code_clr = 1'b0; tick(3);
        pulse_code(6);
        check("R12 strobe high", int'(standby), 1);
        commit_n = 1'b0; tick(4);
        check("R12 active code", int'(standby), 0);
        commit_n = 1'b1; tick(5);
        code_clr = 1'b1; tick(3); code_clr = 1'b0; tick(3);
        commit_n = 1'b0; tick(4);
        check("R12 code zero", int'(standby), 1);
        commit_n = 1'b1; tick(5);
    endtask

    task automatic t_id();
        go_addr(7);
        run_op(2, SHORT_OK);
        port_in = 8'h5A; run_op(5, LONG_OK + 10);
        run_op(10, SHORT_OK);
        read_port("R10 id write/read", 8'h5A);
        pulse_addr(57);
        check("R4 addr 64", int'(mem_addr), 64);
        port_in = 8'h00; run_op(5, LONG_OK + 10);
        run_op(10, SHORT_OK);
        read_port("R10 id out of range", 8'hFF);
    endtask

    task automatic t_addr_clr();
        addr_clr_n = 1'b0; tick(5);
        check("R3 addr cleared", int'(mem_addr), 0);
        check("R3 lock cleared", int'(lock_status), 0);
        addr_clr_n = 1'b1; tick(4);
        pulse_addr(7);
        run_op(10, SHORT_OK);
        read_port("R8 id read while locked", 8'h5A);
        run_op(1, SHORT_OK);
        read_port("R8 memory read denied", 8'h5A);
    endtask

    task automatic t_lock();
        run_op(2, SHORT_OK);
        check("R6 unlock before lock", int'(lock_status), 1);
        run_op(4, SHORT_OK);
        check("R7 lock clears status", int'(lock_status), 0);
        run_op(2, SHORT_OK);
        check("R6 unlock refused", int'(lock_status), 0);
        go_addr(0);
        run_op(2, SHORT_OK);
        run_op(9, SHORT_OK);
        read_port("R7 stays locked", 8'h00);
    endtask

    initial begin
        tick(3); rst = 1'b0; tick(3);
        t_reset();
        t_denied_write();
        t_write_and();
        t_width();
        t_code_clear();
        t_standby();
        t_id();
        t_addr_clr();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule